// File: doc/BRIEF.md
# Fractional Timebase Prescaler

This block advances a free-running timebase counter at a rate derived from one of two single-cycle tick inputs. A control register picks which tick stream drives it (a crystal-derived tick or a core-clock tick). It also sets whether each timebase event adds one or two to the counter. A prescaler register scales the selected tick rate by a fraction. The event rate is the tick rate multiplied by the prescaler value over 2^31. Setting the prescaler to 0x80000000 therefore gives exactly one event per tick.

The scaling uses a phase accumulator. On every selected tick the clamped prescaler value is added to the accumulator. When the sum reaches 2^31, one event is produced and the amount above 2^31 is carried into the next tick. Both registers are written through simple write-enable and data ports. The counter value is read directly from an output port. Tick inputs are assumed to be synchronous to the block clock already.

Top module: `timebase_scaler`

## Requirements
- R1: After reset the counter reads 0, the source selects the crystal tick, the step is 1 and the prescaler is 0, so ticks alone do not move the counter.
- R2: Control bit 8 picks the tick source: 0 means crystal tick, 1 means core tick. The unselected tick input has no effect on the counter. A control write takes effect for ticks from the following cycle.
- R3: Control bit 9 picks the step: 0 adds 1 to the counter per event, 1 adds 2. The counter never advances by more than 2 in one cycle.
- R4: On each selected tick the prescaler value is added to the accumulator. Reaching 2^31 or more produces one event, and the accumulator keeps the sum minus 2^31. For example, 0x40000000 yields one event every second tick.
- R5: A prescaler of 0x80000000 produces one event on every selected tick.
- R6: A prescaler of 0 produces no events.
- R7: Prescaler values above 0x80000000 act as 0x80000000, giving one event per tick.
- R8: A prescaler write clears the accumulator. A tick in the same cycle as the write produces no event and is not accumulated.
- R9: The counter is CNT_W bits wide (64 by default) and wraps to zero on overflow.
- R10: The counter updates on the clock edge that samples the tick, with no further latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 32 | Control write data (bit 8 source, bit 9 step) |
| pre_we_i | input | 1 | Prescaler register write strobe |
| pre_wdata_i | input | PRE_W (32) | Prescaler write data |
| xtal_tick_i | input | 1 | Crystal-derived tick, one cycle wide |
| core_tick_i | input | 1 | Core-clock tick, one cycle wide |
| count_o | output | CNT_W (64) | Timebase counter value |

## Verification
An accumulator holding the wrong remainder does not show up at once. It first appears as an event that comes one tick early or late. That happens within at most 2^31 / prescaler ticks, and it is permanent, because the error carries forward. A wrong source or step bit shows on the very next selected tick as a missing or wrongly sized count change. A clamp or clear fault shows on the first tick after the relevant prescaler write. Every cycle's counter value is compared, so any of these faults is caught in the cycle it first reaches the counter.

// File: rtl/timebase_scaler.sv
module timebase_scaler #(
  parameter int CNT_W    = 64,
  parameter int PRE_W    = 32,
  parameter int CTRL_W   = 32,
  parameter int SRC_BIT  = 8,
  parameter int STEP_BIT = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic             pre_we_i,
  input  logic [PRE_W-1:0] pre_wdata_i,
  input  logic             xtal_tick_i,
  input  logic             core_tick_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [PRE_W-1:0] UNITY = PRE_W'(1) << (PRE_W - 1);

  logic             src_q, step2_q;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-2:0] acc_q;
  logic [CNT_W-1:0] cnt_q;

  logic             tick;
  logic [PRE_W-1:0] pre_eff;
  logic [PRE_W-1:0] sum;
  logic             fire;
  logic             unused_ctrl_bits;

  assign tick    = src_q ? core_tick_i : xtal_tick_i;
  assign pre_eff = (pre_q > UNITY) ? UNITY : pre_q;
  assign sum     = {1'b0, acc_q} + pre_eff;
  assign fire    = tick & ~pre_we_i & sum[PRE_W-1];
  assign count_o = cnt_q;
  assign unused_ctrl_bits = ^ctrl_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= 1'b0;
      step2_q <= 1'b0;
    end else if (ctrl_we_i) begin
      src_q   <= ctrl_wdata_i[SRC_BIT];
      step2_q <= ctrl_wdata_i[STEP_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      acc_q <= '0;
    end else if (pre_we_i) begin
      pre_q <= pre_wdata_i;
      acc_q <= '0;
    end else if (tick) begin
      acc_q <= sum[PRE_W-2:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (fire) cnt_q <= cnt_q + (step2_q ? CNT_W'(2) : CNT_W'(1));
  end
endmodule

// File: rtl/timebase_scaler_chk.sv
module timebase_scaler_chk #(
  parameter int CNT_W = 64,
  parameter int PRE_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             xtal_tick_i,
  input logic             core_tick_i,
  input logic             pre_we_i,
  input logic             src_q,
  input logic             step2_q,
  input logic [PRE_W-1:0] pre_q,
  input logic [CNT_W-1:0] count_o
);
  localparam logic [PRE_W-1:0] UNITY = PRE_W'(1) << (PRE_W - 1);

  a_r1_reset_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> count_o == '0);

  a_r2_unselected_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_q ? !core_tick_i : !xtal_tick_i) |=> $stable(count_o));

  a_r3_step_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> CNT_W'(count_o - $past(count_o)) <= CNT_W'(2));

  a_r3_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step2_q |=> CNT_W'(count_o - $past(count_o)) <= CNT_W'(1));

  a_r5_full_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_q >= UNITY && !pre_we_i && (src_q ? core_tick_i : xtal_tick_i))
    |=> count_o != $past(count_o));

  a_r6_zero_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q == '0 |=> $stable(count_o));

  a_r8_write_drops_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_we_i |=> $stable(count_o));
endmodule

bind timebase_scaler timebase_scaler_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .xtal_tick_i(xtal_tick_i),
  .core_tick_i(core_tick_i),
  .pre_we_i   (pre_we_i),
  .src_q      (src_q),
  .step2_q    (step2_q),
  .pre_q      (pre_q),
  .count_o    (count_o)
);

// File: tb/test_timebase_scaler.sv
module test_timebase_scaler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [31:0] ctrl_wd = '0;
  logic        pre_we = 1'b0;
  logic [31:0] pre_wd = '0;
  logic        xt = 1'b0;
  logic        ct = 1'b0;
  logic [63:0] cnt;
  logic [7:0]  cnt_n;

  always #10 clk = ~clk;

  timebase_scaler i_timebase_scaler (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd),
    .pre_we_i(pre_we), .pre_wdata_i(pre_wd), .xtal_tick_i(xt), .core_tick_i(ct),
    .count_o(cnt));

  timebase_scaler #(.CNT_W(8)) i_timebase_scaler_narrow (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd),
    .pre_we_i(pre_we), .pre_wdata_i(pre_wd), .xtal_tick_i(xt), .core_tick_i(ct),
    .count_o(cnt_n));

  typedef struct {
    logic [63:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic        m_src = 0, m_step2 = 0;
  logic [31:0] m_pre = '0;
  longint      m_acc = 0;
  logic [63:0] m_cnt = '0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit cwe, input logic [31:0] cw, input bit pwe, input logic [31:0] pw,
                     input bit x, input bit c, input string tag);
    longint eff, s;
    bit t;
    item_t it;
    @(negedge clk);
    ctrl_we = cwe; ctrl_wd = cw; pre_we = pwe; pre_wd = pw; xt = x; ct = c;
    t = m_src ? c : x;
    if (pwe) begin
      m_pre = pw; m_acc = 0;
    end else if (t) begin
      eff = (m_pre > 32'h8000_0000) ? 64'h8000_0000 : longint'(m_pre);
      s = m_acc + eff;
      if (s >= 64'h8000_0000) begin
        m_cnt = m_cnt + (m_step2 ? 64'd2 : 64'd1);
        s = s - 64'h8000_0000;
      end
      m_acc = s;
    end
    if (cwe) begin
      m_src = cw[8]; m_step2 = cw[9];
    end
    it.exp = m_cnt; it.tag = tag;
    sb.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(cnt == it.exp, it.tag, cnt, it.exp);
      check(cnt_n == it.exp[7:0], "R9 narrow wrap", 64'(cnt_n), 64'(it.exp[7:0]));
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    #35;
    check(cnt == 0, "R1 reset count", cnt, 0);
    @(negedge clk); rst_n = 1'b1;
    // R1 / R6: zero prescaler after reset, ticks do nothing
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, 1, "R1 R6 idle after reset");
    // R5: unity ratio, R2: core tick ignored while crystal is selected
    cyc(0, 0, 1, 32'h8000_0000, 0, 0, "R5 write unity");
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 1, 0, "R5 one per tick");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 1, "R2 core ignored");
    // R2: switch to core; crystal tick in the write cycle still counts (R10)
    cyc(1, 32'h100, 0, 0, 1, 0, "R2 R10 old source in write cycle");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 0, "R2 crystal ignored");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 1, "R2 core counts");
    // R3: step of two, back on crystal
    cyc(1, 32'h200, 0, 0, 0, 0, "R3 set step2");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, 1, "R3 step two");
    cyc(1, 32'h000, 0, 0, 1, 0, "R3 step back to one");
    cyc(0, 0, 0, 0, 1, 0, "R3 step one");
    // R4: half rate, then irregular fraction with gappy ticks
    cyc(0, 0, 1, 32'h4000_0000, 0, 0, "R4 write half");
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 1, 0, "R4 half rate");
    cyc(0, 0, 1, 32'h2AAA_AAAB, 0, 0, "R4 write third");
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(0, 0, 0, 0, lfsr[0], lfsr[1], "R4 fractional");
    end
    // R8: clear accumulator; tick in write cycle dropped
    cyc(0, 0, 1, 32'h4000_0000, 0, 0, "R8 setup");
    cyc(0, 0, 0, 0, 1, 0, "R8 half accumulated");
    cyc(0, 0, 1, 32'h4000_0000, 1, 0, "R8 tick in write cycle dropped");
    cyc(0, 0, 0, 0, 1, 0, "R8 accumulator cleared, no event");
    cyc(0, 0, 0, 0, 1, 0, "R8 event after two ticks");
    // R7: clamp above unity
    cyc(0, 0, 1, 32'hFFFF_FFFF, 0, 0, "R7 write max");
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 1, 0, "R7 clamped one per tick");
    cyc(0, 0, 1, 32'h8000_0001, 0, 0, "R7 write just above");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 0, "R7 clamped just above");
    // R6: zero prescaler stops the counter
    cyc(0, 0, 1, 32'h0, 0, 0, "R6 write zero");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, 1, "R6 no events");
    // R9: wrap the narrow counter several times with step two
    cyc(1, 32'h200, 1, 32'h8000_0000, 0, 0, "R9 setup");
    for (int i = 0; i < 300; i++) cyc(0, 0, 0, 0, 1, 0, "R9 long run");
    @(negedge clk);
    xt = 0; ct = 0; ctrl_we = 0; pre_we = 0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule